// File: doc/BRIEF.md
# Three-Level DMA Address Sequencer

This block turns one transfer description into a stream of element requests, one per array. A transfer is built from arrays of a fixed byte length; a run of arrays forms a frame, and a run of frames forms a block. For each array the block emits one beat carrying the source byte address, the destination byte address and the array length. Moving the data is left to the bus engine downstream. Each side (source and destination) has its own signed stride between arrays and its own signed stride between frame starts. Either side can be pinned to a fixed address, which is how a device FIFO is served.

The transfer is described with a one-cycle load strobe and advances only on sync events. In array-sync mode each event releases one array. In frame-sync mode each event releases a whole frame, one beat per cycle. In array-sync mode the second and later frames take their array count from a separate reload value. The final beat of the block carries a one-cycle done pulse and the completion code of the transfer. After that the block stays silent until the next load.

Top module: `dmaseq_top`

## Requirements
- R1: After reset, and until the first load, `beat_valid_o` and `done_o` stay low whatever `sync_i` does.
- R2: In array-sync mode (`cfg_frame_sync_i`=0), a sync event sampled at a rising edge while a transfer is armed gives exactly one beat in the following cycle, with `beat_len_o` equal to the loaded array length. Events held on back-to-back cycles give one beat per cycle.
- R3: In frame-sync mode (`cfg_frame_sync_i`=1), a sync event gives one beat per cycle for every array of the current frame, starting in the following cycle. Sync events seen while that frame is still being issued have no effect.
- R4: Within a frame, each side's array address equals the previous array's address plus that side's array stride, taken as a signed two's-complement value and sign-extended. In `cfg_bidx_i` the source stride is the low half and the destination stride is the high half.
- R5: The first array of each frame after the first sits at the previous frame's first-array address plus the signed frame stride. In `cfg_cidx_i` the source stride is the low half and the destination stride is the high half.
- R6: The first frame holds `cfg_bcnt_i` arrays. In array-sync mode every later frame holds `cfg_brld_i` arrays; in frame-sync mode every frame holds `cfg_bcnt_i` arrays. All counts are at least one.
- R7: When a side's fixed-address flag is set, that side's address stays at its start address on every beat. `beat_fifo_w_o` carries the loaded width code when either flag is set, and is zero otherwise.
- R8: `done_o` is high for exactly one cycle, in the cycle of the final beat of the final frame, and `done_code_o` then equals the loaded completion code.
- R9: After done, sync events produce no beats until a new load.
- R10: A load takes effect at once, even during a transfer, and discards the old transfer. No beat and no done appear in the cycle after a load, even if sync was high in the load cycle.
- R11: Address arithmetic wraps modulo 2^AW in both directions.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| load_i | input | 1 | Capture a new transfer description |
| cfg_acnt_i | input | CW | Bytes per array |
| cfg_bcnt_i | input | CW | Arrays in the first frame |
| cfg_ccnt_i | input | CW | Frames per block |
| cfg_brld_i | input | CW | Arrays per later frame, array-sync mode |
| cfg_src_i | input | AW | Source start address |
| cfg_dst_i | input | AW | Destination start address |
| cfg_bidx_i | input | 2*IW | Array strides: source low half, destination high half |
| cfg_cidx_i | input | 2*IW | Frame strides: source low half, destination high half |
| cfg_frame_sync_i | input | 1 | 0 = one array per event, 1 = one frame per event |
| cfg_src_fix_i | input | 1 | Hold source address fixed |
| cfg_dst_fix_i | input | 1 | Hold destination address fixed |
| cfg_fifo_w_i | input | FW | FIFO width code |
| cfg_code_i | input | KW | Completion code |
| sync_i | input | 1 | Sync event |
| beat_valid_o | output | 1 | Beat present this cycle |
| beat_src_o | output | AW | Source address of the array |
| beat_dst_o | output | AW | Destination address of the array |
| beat_len_o | output | CW | Array length in bytes |
| beat_fifo_w_o | output | FW | Width code while a side is fixed |
| done_o | output | 1 | Final beat of the block |
| done_code_o | output | KW | Completion code, valid with done |

## Verification
The bench builds the block with a 16-bit address, 8-bit counts and 8-bit strides. With an 8-bit stride, negative strides and both address wrap directions are reached with a few arrays. With 8-bit counts, whole blocks with several frames finish within a few dozen cycles. Every cycle is compared against a model that lays out each block's beat list in advance, frame by frame. Extra sync pulses are placed inside frame bursts and after done, and a reload is issued with sync high in the middle of a transfer.

// File: rtl/dmaseq_pkg.sv
package dmaseq_pkg;
    localparam int SIDES    = 2;
    localparam int SIDE_SRC = 0;
    localparam int SIDE_DST = 1;

    typedef enum logic {
        SYNC_ARRAY = 1'b0,
        SYNC_FRAME = 1'b1
    } sync_mode_e;
endpackage

// File: rtl/dmaseq_side.sv
// Address walker for one side (source or destination).
module dmaseq_side #(
    parameter int AW = 32,
    parameter int IW = 16
) (
    input  logic          clk_i,
    input  logic          rst_n,
    input  logic          load_i,
    input  logic [AW-1:0] start_i,
    input  logic [IW-1:0] bidx_i,
    input  logic [IW-1:0] cidx_i,
    input  logic          hold_i,
    input  logic          step_i,
    input  logic          frame_end_i,
    output logic [AW-1:0] addr_o
);
    localparam int EXT = AW - IW;

    typedef struct packed {
        logic [AW-1:0] arr;
        logic [AW-1:0] frm;
        logic [IW-1:0] bidx;
        logic [IW-1:0] cidx;
    } side_t;

    side_t st_d, st_q;
    logic [AW-1:0] bstep, cstep;

    always_comb begin
        bstep = {{EXT{st_q.bidx[IW-1]}}, st_q.bidx};
        cstep = {{EXT{st_q.cidx[IW-1]}}, st_q.cidx};
        st_d  = st_q;
        if (load_i) begin
            st_d.arr  = start_i;
            st_d.frm  = start_i;
            st_d.bidx = bidx_i;
            st_d.cidx = cidx_i;
        end else if (step_i && !hold_i) begin
            if (frame_end_i) begin
                st_d.frm = st_q.frm + cstep;
                st_d.arr = st_q.frm + cstep;
            end else begin
                st_d.arr = st_q.arr + bstep;
            end
        end
    end

    always_ff @(posedge clk_i or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign addr_o = st_q.arr;
endmodule

// File: rtl/dmaseq_count.sv
// Array / frame countdown with reload selection.
module dmaseq_count #(
    parameter int CW = 16
) (
    input  logic          clk_i,
    input  logic          rst_n,
    input  logic          load_i,
    input  logic [CW-1:0] bcnt_i,
    input  logic [CW-1:0] ccnt_i,
    input  logic [CW-1:0] brld_i,
    input  logic          frame_sync_i,
    input  logic          step_i,
    output logic          last_arr_o,
    output logic          last_blk_o
);
    typedef struct packed {
        logic [CW-1:0] b_left;
        logic [CW-1:0] c_left;
        logic [CW-1:0] b_full;
        logic [CW-1:0] b_rld;
    } cnt_t;

    localparam logic [CW-1:0] ONE = CW'(1);

    cnt_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (load_i) begin
            st_d.b_left = bcnt_i;
            st_d.c_left = ccnt_i;
            st_d.b_full = bcnt_i;
            st_d.b_rld  = brld_i;
        end else if (step_i) begin
            if (st_q.b_left == ONE) begin
                if (st_q.c_left != ONE) begin
                    st_d.c_left = st_q.c_left - ONE;
                    st_d.b_left = frame_sync_i ? st_q.b_full : st_q.b_rld;
                end
            end else begin
                st_d.b_left = st_q.b_left - ONE;
            end
        end
    end

    always_ff @(posedge clk_i or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign last_arr_o = (st_q.b_left == ONE);
    assign last_blk_o = last_arr_o && (st_q.c_left == ONE);
endmodule

// File: rtl/dmaseq_top.sv
module dmaseq_top
    import dmaseq_pkg::*;
#(
    parameter int AW = 32,
    parameter int CW = 16,
    parameter int IW = 16,
    parameter int FW = 3,
    parameter int KW = 6
) (
    input  logic            clk_i,
    input  logic            rst_n,
    input  logic            load_i,
    input  logic [CW-1:0]   cfg_acnt_i,
    input  logic [CW-1:0]   cfg_bcnt_i,
    input  logic [CW-1:0]   cfg_ccnt_i,
    input  logic [CW-1:0]   cfg_brld_i,
    input  logic [AW-1:0]   cfg_src_i,
    input  logic [AW-1:0]   cfg_dst_i,
    input  logic [2*IW-1:0] cfg_bidx_i,
    input  logic [2*IW-1:0] cfg_cidx_i,
    input  logic            cfg_frame_sync_i,
    input  logic            cfg_src_fix_i,
    input  logic            cfg_dst_fix_i,
    input  logic [FW-1:0]   cfg_fifo_w_i,
    input  logic [KW-1:0]   cfg_code_i,
    input  logic            sync_i,
    output logic            beat_valid_o,
    output logic [AW-1:0]   beat_src_o,
    output logic [AW-1:0]   beat_dst_o,
    output logic [CW-1:0]   beat_len_o,
    output logic [FW-1:0]   beat_fifo_w_o,
    output logic            done_o,
    output logic [KW-1:0]   done_code_o
);
    typedef struct packed {
        logic             armed;
        logic             burst;
        sync_mode_e       mode;
        logic [SIDES-1:0] konst;
        logic [FW-1:0]    fw;
        logic [KW-1:0]    code;
        logic [CW-1:0]    acnt;
        logic             beat_valid;
        logic [AW-1:0]    beat_src;
        logic [AW-1:0]    beat_dst;
        logic [CW-1:0]    beat_len;
        logic [FW-1:0]    beat_fw;
        logic             done;
    } top_t;

    top_t          st_d, st_q;
    logic          step;
    logic          last_arr, last_blk;
    logic [AW-1:0] cur_addr [SIDES];
    logic [AW-1:0] start_addr [SIDES];

    assign start_addr[SIDE_SRC] = cfg_src_i;
    assign start_addr[SIDE_DST] = cfg_dst_i;
    assign step = st_q.armed && (st_q.burst || sync_i) && !load_i;

    dmaseq_count #(.CW(CW)) u_count (
        .clk_i        (clk_i),
        .rst_n        (rst_n),
        .load_i       (load_i),
        .bcnt_i       (cfg_bcnt_i),
        .ccnt_i       (cfg_ccnt_i),
        .brld_i       (cfg_brld_i),
        .frame_sync_i (st_q.mode == SYNC_FRAME),
        .step_i       (step),
        .last_arr_o   (last_arr),
        .last_blk_o   (last_blk)
    );

    for (genvar s = 0; s < SIDES; s++) begin : g_side
        dmaseq_side #(.AW(AW), .IW(IW)) u_side (
            .clk_i       (clk_i),
            .rst_n       (rst_n),
            .load_i      (load_i),
            .start_i     (start_addr[s]),
            .bidx_i      (cfg_bidx_i[s*IW +: IW]),
            .cidx_i      (cfg_cidx_i[s*IW +: IW]),
            .hold_i      (st_q.konst[s]),
            .step_i      (step),
            .frame_end_i (last_arr),
            .addr_o      (cur_addr[s])
        );
    end

    always_comb begin
        st_d            = st_q;
        st_d.beat_valid = 1'b0;
        st_d.done       = 1'b0;
        if (load_i) begin
            st_d.armed           = 1'b1;
            st_d.burst           = 1'b0;
            st_d.mode            = sync_mode_e'(cfg_frame_sync_i);
            st_d.konst[SIDE_SRC] = cfg_src_fix_i;
            st_d.konst[SIDE_DST] = cfg_dst_fix_i;
            st_d.fw              = cfg_fifo_w_i;
            st_d.code            = cfg_code_i;
            st_d.acnt            = cfg_acnt_i;
        end else if (step) begin
            st_d.beat_valid = 1'b1;
            st_d.beat_src   = cur_addr[SIDE_SRC];
            st_d.beat_dst   = cur_addr[SIDE_DST];
            st_d.beat_len   = st_q.acnt;
            st_d.beat_fw    = (|st_q.konst) ? st_q.fw : '0;
            if (last_blk) begin
                st_d.done  = 1'b1;
                st_d.armed = 1'b0;
                st_d.burst = 1'b0;
            end else begin
                st_d.burst = (st_q.mode == SYNC_FRAME) && !last_arr;
            end
        end
    end

    always_ff @(posedge clk_i or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign beat_valid_o  = st_q.beat_valid;
    assign beat_src_o    = st_q.beat_src;
    assign beat_dst_o    = st_q.beat_dst;
    assign beat_len_o    = st_q.beat_len;
    assign beat_fifo_w_o = st_q.beat_fw;
    assign done_o        = st_q.done;
    assign done_code_o   = st_q.code;
endmodule

// File: rtl/dmaseq_chk.sv
module dmaseq_chk #(
    parameter int AW = 32
) (
    input logic          clk,
    input logic          rst_n,
    input logic          load_i,
    input logic          beat_valid,
    input logic          done,
    input logic          burst,
    input logic [1:0]    hold,
    input logic [AW-1:0] src_addr,
    input logic [AW-1:0] dst_addr
);
    assert_done_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    assert_done_on_beat_R8: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> beat_valid);

    assert_quiet_after_done_R9: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !beat_valid);

    assert_load_silent_R10: assert property (@(posedge clk) disable iff (!rst_n)
        load_i |=> (!beat_valid && !done));

    assert_burst_continues_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (burst && !load_i) |=> beat_valid);

    assert_src_fixed_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (hold[0] && !load_i) |=> $stable(src_addr));

    assert_dst_fixed_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (hold[1] && !load_i) |=> $stable(dst_addr));
endmodule

bind dmaseq_top dmaseq_chk #(.AW(AW)) u_chk (
    .clk        (clk_i),
    .rst_n      (rst_n),
    .load_i     (load_i),
    .beat_valid (beat_valid_o),
    .done       (done_o),
    .burst      (st_q.burst),
    .hold       (st_q.konst),
    .src_addr   (cur_addr[0]),
    .dst_addr   (cur_addr[1])
);

// File: tb/dmaseq_top_tb_top.sv
`timescale 1ns/1ps
module dmaseq_top_tb_top;
    localparam int AW = 16, CW = 8, IW = 8, FW = 3, KW = 6;
    localparam int MASK = (1 << AW) - 1;

    logic clk = 0, rst_n = 0;
    always #5 clk = ~clk;

    logic            load = 0, sync = 0;
    logic [CW-1:0]   acnt = 0, bcnt = 0, ccnt = 0, brld = 0;
    logic [AW-1:0]   src = 0, dst = 0;
    logic [2*IW-1:0] bidx = 0, cidx = 0;
    logic            fsync = 0, sfix = 0, dfix = 0;
    logic [FW-1:0]   fw = 0;
    logic [KW-1:0]   code = 0;

    logic            beat_valid, done;
    logic [AW-1:0]   beat_src, beat_dst;
    logic [CW-1:0]   beat_len;
    logic [FW-1:0]   beat_fw;
    logic [KW-1:0]   done_code;

    dmaseq_top #(.AW(AW), .CW(CW), .IW(IW), .FW(FW), .KW(KW)) dut_i (
        .clk_i(clk), .rst_n(rst_n), .load_i(load),
        .cfg_acnt_i(acnt), .cfg_bcnt_i(bcnt), .cfg_ccnt_i(ccnt), .cfg_brld_i(brld),
        .cfg_src_i(src), .cfg_dst_i(dst), .cfg_bidx_i(bidx), .cfg_cidx_i(cidx),
        .cfg_frame_sync_i(fsync), .cfg_src_fix_i(sfix), .cfg_dst_fix_i(dfix),
        .cfg_fifo_w_i(fw), .cfg_code_i(code), .sync_i(sync),
        .beat_valid_o(beat_valid), .beat_src_o(beat_src), .beat_dst_o(beat_dst),
        .beat_len_o(beat_len), .beat_fifo_w_o(beat_fw), .done_o(done),
        .done_code_o(done_code)
    );

    int total = 0, bad = 0;
    string tag = "R1";
    int beats_seen = 0, dones_seen = 0;

    // reference model: beat list laid out at load time
    int q_src[$], q_dst[$];
    bit q_eof[$];
    bit m_armed = 0, m_burst = 0, m_ab = 0;
    int m_len = 0, m_fw = 0, m_code = 0;
    bit e_valid = 0, e_done = 0;
    int e_src = 0, e_dst = 0, e_len = 0, e_fw = 0;

    task automatic chk(input string t, input string what, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s %s actual=%0h expected=%0h", t, what, act, exp);
        end
    endtask

    function automatic int sx(input logic [IW-1:0] v);
        return int'($signed(v));
    endfunction

    task automatic build();
        int sb, db, sc, dc, n;
        sb = sx(bidx[IW-1:0]); db = sx(bidx[2*IW-1:IW]);
        sc = sx(cidx[IW-1:0]); dc = sx(cidx[2*IW-1:IW]);
        q_src.delete(); q_dst.delete(); q_eof.delete();
        for (int f = 0; f < int'(ccnt); f++) begin
            n = (fsync || f == 0) ? int'(bcnt) : int'(brld);
            for (int k = 0; k < n; k++) begin
                q_src.push_back(sfix ? int'(src) : (int'(src) + f*sc + k*sb) & MASK);
                q_dst.push_back(dfix ? int'(dst) : (int'(dst) + f*dc + k*db) & MASK);
                q_eof.push_back(k == n-1);
            end
        end
    endtask

    always @(posedge clk) begin
        if (!rst_n) begin
            m_armed = 0; m_burst = 0; e_valid = 0; e_done = 0;
        end else begin
            e_valid = 0; e_done = 0;
            if (load) begin
                build();
                m_armed = 1; m_burst = 0; m_ab = fsync;
                m_len = int'(acnt); m_code = int'(code);
                m_fw = (sfix || dfix) ? int'(fw) : 0;
            end else if (m_armed && (m_burst || sync)) begin
                bit eof;
                e_valid = 1;
                e_src = q_src.pop_front();
                e_dst = q_dst.pop_front();
                eof = q_eof.pop_front();
                e_len = m_len; e_fw = m_fw;
                if (q_src.size() == 0) begin
                    e_done = 1; m_armed = 0; m_burst = 0;
                end else begin
                    m_burst = m_ab && !eof;
                end
            end
        end
    end

    always @(negedge clk) begin
        if (rst_n) begin
            chk(tag, "beat_valid", int'(beat_valid), int'(e_valid));
            chk(tag, "done", int'(done), int'(e_done));
            if (e_valid) begin
                chk(tag, "src", int'(beat_src), e_src);
                chk(tag, "dst", int'(beat_dst), e_dst);
                chk(tag, "len", int'(beat_len), e_len);
                chk(tag, "fifo_w", int'(beat_fw), e_fw);
            end
            if (e_done) chk(tag, "code", int'(done_code), m_code);
            if (beat_valid) beats_seen++;
            if (done) dones_seen++;
        end
    end

    task automatic load_cfg(input bit ab, input int a, b, c, r, s, d,
                            input int sb, db, sc, dc, input bit sk, dk,
                            input int w, k, input bit with_sync);
        @(negedge clk);
        fsync = ab; acnt = CW'(a); bcnt = CW'(b); ccnt = CW'(c); brld = CW'(r);
        src = AW'(s); dst = AW'(d);
        bidx = {IW'(db), IW'(sb)}; cidx = {IW'(dc), IW'(sc)};
        sfix = sk; dfix = dk; fw = FW'(w); code = KW'(k);
        load = 1; sync = with_sync;
        @(negedge clk);
        load = 0; sync = 0;
        beats_seen = 0; dones_seen = 0;
    endtask

    task automatic pulse(input int gap);
        @(negedge clk); sync = 1;
        @(negedge clk); sync = 0;
        repeat (gap) @(negedge clk);
    endtask

    initial begin : wdog
        repeat (20000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        chk("R1", "reset beat_valid", int'(beat_valid), 0);
        chk("R1", "reset done", int'(done), 0);
        rst_n = 1;
        tag = "R1";
        pulse(2); pulse(2);
        chk("R1", "beats before load", beats_seen, 0);

        // array-sync, negative dst stride, reload on later frames
        tag = "R2 R4 R5 R6";
        load_cfg(0, 4, 3, 2, 2, 'h1000, 'h2000, 4, -8, 32, 100, 0, 0, 5, 5, 0);
        for (int i = 0; i < 5; i++) pulse(2);
        chk("R6", "array count with reload", beats_seen, 5);
        chk("R8", "done count", dones_seen, 1);
        tag = "R9";
        for (int i = 0; i < 3; i++) pulse(1);
        chk("R9", "beats after done", beats_seen, 5);

        // back-to-back syncs
        tag = "R2 R6";
        load_cfg(0, 1, 2, 3, 3, 'h0100, 'h0200, 1, 2, 16, -16, 0, 0, 0, 9, 0);
        @(negedge clk); sync = 1;
        repeat (10) @(negedge clk);
        sync = 0;
        repeat (2) @(negedge clk);
        chk("R2", "back-to-back beat count", beats_seen, 8);

        // frame-sync, extra sync inside each burst
        tag = "R3 R5 R6";
        load_cfg(1, 8, 4, 3, 1, 'h3000, 'h4000, 8, 8, -64, 64, 0, 0, 0, 17, 0);
        for (int f = 0; f < 3; f++) begin
            pulse(1); pulse(6);
        end
        chk("R3", "frame-sync beat count", beats_seen, 12);
        chk("R8", "frame-sync done", dones_seen, 1);

        // fixed destination, frame-sync
        tag = "R7";
        load_cfg(1, 4, 3, 2, 1, 'h5000, 'h6000, 4, 4, 16, 16, 0, 1, 2, 33, 0);
        pulse(5); pulse(5);
        chk("R7", "fixed dst beat count", beats_seen, 6);
        // fixed source, array-sync
        load_cfg(0, 2, 2, 2, 1, 'h7000, 'h7100, 4, 4, 16, 16, 1, 0, 6, 34, 0);
        for (int i = 0; i < 3; i++) pulse(1);
        chk("R7", "fixed src beat count", beats_seen, 3);

        // wrap both directions
        tag = "R11";
        load_cfg(0, 2, 3, 1, 1, 'hFFF0, 'h0008, 16, -16, 0, 0, 0, 0, 0, 40, 0);
        for (int i = 0; i < 3; i++) pulse(1);
        chk("R11", "wrap beat count", beats_seen, 3);

        // restart mid-transfer with sync high at the load
        tag = "R10";
        load_cfg(0, 4, 4, 2, 4, 'h1100, 'h2200, 4, 4, 64, 64, 0, 0, 0, 11, 0);
        pulse(1); pulse(1);
        load_cfg(0, 8, 2, 2, 1, 'h8000, 'h9000, 8, -8, 32, -32, 0, 0, 0, 22, 1);
        chk("R10", "no beat after load", beats_seen, 0);
        for (int i = 0; i < 3; i++) pulse(1);
        chk("R10", "restarted beat count", beats_seen, 3);
        chk("R10", "restarted done", dones_seen, 1);

        // single array block
        tag = "R8";
        load_cfg(1, 3, 1, 1, 1, 'h0040, 'h0080, 0, 0, 0, 0, 0, 0, 0, 63, 0);
        pulse(3);
        chk("R8", "single-array done", dones_seen, 1);

        repeat (3) @(negedge clk);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule